// File: doc/BRIEF.md
# Image Sensor Readout Sequencer

This block drives the readout of a 176 by 144 pixel array, one frame at a time. A frame starts on a one-cycle request. The block then visits the rows in ascending order. For each row it raises the row enable with the row index and pulses the pixel reset for one cycle. It then holds the integration control for a programmed number of clock cycles. The integration length is captured when the frame starts and stays fixed until the next frame.

Each pixel of the row is read in column order. The block strobes a reset-level sample, then a signal-level sample, and then a conversion request to the single shared converter. The column address stays put until the converter answers with its done pulse. The returned 8-bit code leaves the block as a registered pixel stream. A valid strobe qualifies each beat and also serves as the downstream clock enable. Markers flag the first pixel of a frame and the last pixel of each line.

Top module: `sensor_readout_seq`

## Requirements
- R1: After reset, every control and stream output is low (row enable, pixel reset, integration, both sample strobes, conversion request, valid, markers).
- R2: A frame request is taken only while the block is idle; a request during a frame has no effect, and each frame yields exactly ROWS×COLS output beats.
- R3: Rows are read in order 0..ROWS-1. Each row gets a one-cycle pixel reset with row_sel equal to the row index, followed by integration held high for exactly max(L,1) cycles, where L is the integration length in effect for the frame.
- R4: The integration length is captured at frame start; changing the int_len input during a frame does not alter the integration of that frame.
- R5: For each pixel, the reset-level strobe, the signal-level strobe and the conversion request each last one cycle, and they come in that order on consecutive cycles.
- R6: The column address steps 0..COLS-1 within a row and holds its value from the reset-level strobe until the done pulse for that pixel.
- R7: A done pulse that arrives while no conversion is outstanding is ignored and produces no output beat.
- R8: The cycle after a done pulse is accepted, pix_valid is high for one cycle, pix_code carries the returned code, and the beats follow raster order.
- R9: frame_first is high only with the beat for row 0, column 0. line_last is high only with the beat for column COLS-1. Both are low when pix_valid is low.
- R10: After the last pixel of the last row, the block returns to idle with row_en low and waits for a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_go | input | 1 | Frame request, taken while idle |
| int_len | input | INT_W | Integration length in clock cycles |
| adc_done | input | 1 | Converter done pulse |
| adc_code | input | 8 | Converter result, valid with adc_done |
| row_en | output | 1 | Row selection active |
| row_sel | output | clog2(ROWS) | Selected row index |
| pix_rst | output | 1 | Pixel reset phase of selected row |
| pix_int | output | 1 | Integration phase of selected row |
| cds_rst_smp | output | 1 | Reset-level sample strobe |
| cds_sig_smp | output | 1 | Signal-level sample strobe |
| col_addr | output | clog2(COLS) | Column multiplexer address |
| adc_start | output | 1 | Conversion request pulse |
| pix_valid | output | 1 | Output beat valid / downstream clock enable |
| pix_code | output | 8 | Pixel code |
| frame_first | output | 1 | First pixel of frame marker |
| line_last | output | 1 | Last pixel of line marker |

## Verification
The assertions check the parts of the order that hold cycle by cycle. The two sample strobes and the conversion request must come in sequence. Pixel reset must go straight into integration, and the column address must hold during a conversion. An output beat may appear only after a done pulse, and the markers must stay low between beats. Other behaviour shows only across a whole frame, so the bench scenarios cover it. These include the row and column order, the integration count per row for several lengths, and a length change or a second request in mid-frame that must be ignored. They also include a stray done pulse, converter latency that varies, and the exact beat count with the marker positions.

// File: rtl/sro_pkg.sv
package sro_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RRST,
        ST_INTG,
        ST_SMPR,
        ST_SMPS,
        ST_CONV,
        ST_WAIT
    } seq_st_e;

    typedef struct packed {
        logic row_en;
        logic pix_rst;
        logic pix_int;
        logic smp_rst;
        logic smp_sig;
        logic conv;
    } ctl_s;

    typedef struct packed {
        logic              first;
        logic              last;
        logic [CODE_W-1:0] code;
    } beat_s;

    function automatic ctl_s ctl_of(seq_st_e s);
        ctl_s c;
        c.row_en  = (s != ST_IDLE);
        c.pix_rst = (s == ST_RRST);
        c.pix_int = (s == ST_INTG);
        c.smp_rst = (s == ST_SMPR);
        c.smp_sig = (s == ST_SMPS);
        c.conv    = (s == ST_CONV);
        return c;
    endfunction

endpackage

// File: rtl/sro_int_timer.sv
module sro_int_timer #(
    parameter int INT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [INT_W-1:0] len,
    input  logic             tick,
    output logic             expired
);
    logic [INT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (len == '0) ? INT_W'(1) : len;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == INT_W'(1));
endmodule

// File: rtl/sro_ctrl.sv
module sro_ctrl
    import sro_pkg::*;
#(
    parameter int COLS  = 176,
    parameter int ROWS  = 144,
    parameter int INT_W = 20,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_go,
    input  logic [INT_W-1:0] int_len,
    input  logic             adc_done,
    input  logic             tmr_exp,
    output seq_st_e          state,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic [INT_W-1:0] len_q,
    output logic             accept
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    assign accept = (state == ST_WAIT) && adc_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            row   <= '0;
            col   <= '0;
            len_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (frame_go) begin
                    len_q <= int_len;
                    row   <= '0;
                    col   <= '0;
                    state <= ST_RRST;
                end
                ST_RRST: state <= ST_INTG;
                ST_INTG: if (tmr_exp) state <= ST_SMPR;
                ST_SMPR: state <= ST_SMPS;
                ST_SMPS: state <= ST_CONV;
                ST_CONV: state <= ST_WAIT;
                ST_WAIT: if (adc_done) begin
                    if (col != COL_LAST) begin
                        col   <= col + 1'b1;
                        state <= ST_SMPR;
                    end else begin
                        col <= '0;
                        if (row != ROW_LAST) begin
                            row   <= row + 1'b1;
                            state <= ST_RRST;
                        end else begin
                            row   <= '0;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    sig_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SMPS) |-> $past(state == ST_SMPR));
    // R5
    conv_after_sig_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV) |-> $past(state == ST_SMPS));
    // R6
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !adc_done) |=> $stable(col));
    // R3
    rst_then_int_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RRST) |=> (state == ST_INTG));
endmodule

// File: rtl/sro_outreg.sv
module sro_outreg
    import sro_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  beat_s beat_in,
    output logic  valid,
    output beat_s beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            beat  <= '0;
        end else begin
            valid <= accept;
            if (accept) begin
                beat <= beat_in;
            end else begin
                beat.first <= 1'b0;
                beat.last  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sensor_readout_seq.sv
module sensor_readout_seq
    import sro_pkg::*;
#(
    parameter int COLS  = 176,
    parameter int ROWS  = 144,
    parameter int INT_W = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_go,
    input  logic [INT_W-1:0]         int_len,
    input  logic                     adc_done,
    input  logic [CODE_W-1:0]        adc_code,
    output logic                     row_en,
    output logic [$clog2(ROWS)-1:0]  row_sel,
    output logic                     pix_rst,
    output logic                     pix_int,
    output logic                     cds_rst_smp,
    output logic                     cds_sig_smp,
    output logic [$clog2(COLS)-1:0]  col_addr,
    output logic                     adc_start,
    output logic                     pix_valid,
    output logic [CODE_W-1:0]        pix_code,
    output logic                     frame_first,
    output logic                     line_last
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);

    seq_st_e          state;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [INT_W-1:0] len_q;
    logic             accept;
    logic             tmr_exp;
    ctl_s             ctl;
    beat_s            beat_in;
    beat_s            beat_q;

    sro_ctrl #(.COLS(COLS), .ROWS(ROWS), .INT_W(INT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .frame_go (frame_go),
        .int_len  (int_len),
        .adc_done (adc_done),
        .tmr_exp  (tmr_exp),
        .state    (state),
        .row      (row),
        .col      (col),
        .len_q    (len_q),
        .accept   (accept)
    );

    sro_int_timer #(.INT_W(INT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (state == ST_RRST),
        .len     (len_q),
        .tick    (state == ST_INTG),
        .expired (tmr_exp)
    );

    always_comb begin
        ctl           = ctl_of(state);
        beat_in.first = (row == '0) && (col == '0);
        beat_in.last  = (col == COL_W'(COLS - 1));
        beat_in.code  = adc_code;
    end

    sro_outreg u_out (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .beat_in (beat_in),
        .valid   (pix_valid),
        .beat    (beat_q)
    );

    assign row_en      = ctl.row_en;
    assign row_sel     = row;
    assign pix_rst     = ctl.pix_rst;
    assign pix_int     = ctl.pix_int;
    assign cds_rst_smp = ctl.smp_rst;
    assign cds_sig_smp = ctl.smp_sig;
    assign col_addr    = col;
    assign adc_start   = ctl.conv;
    assign pix_code    = beat_q.code;
    assign frame_first = beat_q.first;
    assign line_last   = beat_q.last;

    // R8
    beat_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(adc_done));
    // R9
    first_marker_chk: assert property (@(posedge clk) disable iff (rst)
        frame_first |-> pix_valid);
    // R9
    last_marker_chk: assert property (@(posedge clk) disable iff (rst)
        line_last |-> pix_valid);
    // R7
    no_beat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INTG) |=> !pix_valid);
endmodule

// File: tb/sensor_readout_seq_test.sv
module sensor_readout_seq_test;
    localparam int C  = 4;
    localparam int R  = 3;
    localparam int IW = 8;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_go = 1'b0;
    logic [IW-1:0] int_len = '0;
    logic adc_done = 1'b0;
    logic [7:0] adc_code = '0;
    logic row_en, pix_rst, pix_int, cds_rst_smp, cds_sig_smp, adc_start;
    logic pix_valid, frame_first, line_last;
    logic [1:0] row_sel, col_addr;
    logic [7:0] pix_code;

    sensor_readout_seq #(.COLS(C), .ROWS(R), .INT_W(IW)) uut (
        .clk(clk), .rst(rst), .frame_go(frame_go), .int_len(int_len),
        .adc_done(adc_done), .adc_code(adc_code), .row_en(row_en),
        .row_sel(row_sel), .pix_rst(pix_rst), .pix_int(pix_int),
        .cds_rst_smp(cds_rst_smp), .cds_sig_smp(cds_sig_smp),
        .col_addr(col_addr), .adc_start(adc_start), .pix_valid(pix_valid),
        .pix_code(pix_code), .frame_first(frame_first), .line_last(line_last)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
    int exp_int = 1, lat_cfg = 1, seed_cfg = 0, tot_out = 0;
    bit spur_req = 1'b0;

    function automatic logic [7:0] code_of(int r, int c);
        return 8'((r * 37 + c * 11 + seed_cfg) & 255);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic mcheck(bit ok, string tag, int act, int exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // converter model
    int busy = 0;
    int cap_r = 0, cap_c = 0;
    always @(negedge clk) begin
        bit d;
        d = spur_req;
        if (spur_req) adc_code = 8'hEE;
        if (busy != 0) begin
            busy--;
            if (busy == 0) begin
                d = 1'b1;
                adc_code = code_of(cap_r, cap_c);
            end
        end
        if (adc_start) begin
            busy  = lat_cfg;
            cap_r = int'(row_sel);
            cap_c = int'(col_addr);
        end
        adc_done = d;
    end

    // monitor
    int p = 0, q = 0, int_cnt = 0;
    bit prev_r = 0, prev_s = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pix_int) int_cnt++;
            if (cds_rst_smp) begin
                mcheck(int'(row_sel) == p / C, "R3 row order", int'(row_sel), p / C);
                mcheck(int'(col_addr) == p % C, "R6 column order", int'(col_addr), p % C);
                if (p % C == 0) begin
                    mcheck(int_cnt == exp_int, "R3/R4 integration length", int_cnt, exp_int);
                    int_cnt = 0;
                end
                p = (p + 1) % (R * C);
            end
            if (cds_sig_smp) mcheck(prev_r, "R5 signal strobe after reset strobe", 0, 1);
            if (adc_start)   mcheck(prev_s, "R5 conversion after signal strobe", 0, 1);
            if (pix_valid) begin
                mcheck(pix_code == code_of(q / C, q % C), "R8 pixel code", int'(pix_code),
                       int'(code_of(q / C, q % C)));
                mcheck(frame_first == (q == 0), "R9 frame_first", int'(frame_first), int'(q == 0));
                mcheck(line_last == (q % C == C - 1), "R9 line_last", int'(line_last),
                       int'(q % C == C - 1));
                q = (q + 1) % (R * C);
                tot_out++;
            end else begin
                mcheck(!frame_first && !line_last, "R9 markers without valid",
                       int'(frame_first) + int'(line_last), 0);
            end
            prev_r = cds_rst_smp;
            prev_s = cds_sig_smp;
        end
    end

    task automatic run_frame(int len, int lat, int seed, bit disturb);
        int target;
        exp_int  = (len == 0) ? 1 : len;
        lat_cfg  = lat;
        seed_cfg = seed;
        int_len  = IW'(len);
        target   = tot_out + R * C;
        @(negedge clk) frame_go = 1'b1;
        @(negedge clk) frame_go = 1'b0;
        if (disturb) begin
            while (!pix_int && cyc < LIMIT) @(negedge clk);
            @(posedge clk);
            spur_req = 1'b1;
            int_len  = IW'(len + 7);
            @(posedge clk);
            spur_req = 1'b0;
            @(negedge clk);
            // R7: stray done during integration gives no beat
            check(!pix_valid, "R7 stray done ignored", int'(pix_valid), 0);
            frame_go = 1'b1;
            @(negedge clk) frame_go = 1'b0;
        end
        while (tot_out < target && cyc < LIMIT) @(negedge clk);
        check(cyc < LIMIT, "watchdog expired", cyc, LIMIT);
        repeat (6) @(negedge clk);
        // R2: exactly one frame of beats, no restart
        check(tot_out == target, "R2 beat count per frame", tot_out, target);
        // R10: back to idle
        check(!row_en, "R10 idle after frame", int'(row_en), 0);
        check(!adc_start && !cds_rst_smp, "R10 no strobes when idle",
              int'(adc_start) + int'(cds_rst_smp), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!row_en && !pix_rst && !pix_int, "R1 row controls low", int'(row_en), 0);
        check(!cds_rst_smp && !cds_sig_smp && !adc_start, "R1 strobes low", int'(adc_start), 0);
        check(!pix_valid && !frame_first && !line_last, "R1 stream low", int'(pix_valid), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!row_en, "R2 no start without request", int'(row_en), 0);
        run_frame(0, 1, 3, 1'b0);
        run_frame(6, 3, 90, 1'b1);
        run_frame(2, 2, 200, 1'b0);
        run_frame(1, 5, 17, 1'b0);
        check(tot_out == 4 * R * C, "R8 total beats", tot_out, 4 * R * C);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + m_chk, n_fail + m_fail);
        $finish;
    end
endmodule